// File: doc/BRIEF.md
# Prescaled Modulo Overflow Timer

This block is an 8-bit up-counter driven by one of four tick sources and scaled by a power-of-two divider. The counter climbs from zero to a programmable limit, returns to zero on the next tick and latches an overflow flag. When the interrupt enable is set, that flag drives an interrupt request. Software controls the timer through four byte-wide registers on a simple bus port. It can halt the counter, restart it, pick the tick source and the divider, and set the limit.

There are four registers. Address 0 is status/control: bit 7 is the overflow flag, bit 6 the interrupt enable, bit 5 a restart strobe and bit 4 the halt bit. Address 1 is the clock setup: bits 5:4 select the source and bits 3:0 the divider code. Address 2 returns the live count. Address 3 holds the limit. Reads return their data combinationally. A write takes effect at the clock edge on which `busWr` is high. A limit of zero makes the counter run over its full 8-bit range.

Top module: `mod_overflow_timer`

## Requirements
- R1: The count (address 2) rises by one on each divided tick, and a write to address 2 leaves the count unchanged.
- R2: With a nonzero limit, the tick taken at count == limit returns the count to 0 and sets the flag (status bit 7).
- R3: A limit of 0 lets the count run to 255, and the next tick returns it to 0 and sets the flag.
- R4: Any write to the limit register (address 3) puts the count at 0 and clears the flag in that same edge.
- R5: After reset the timer is halted: status reads 0x10, and clock setup, count and limit all read 0. While status bit 4 is 1 the count holds.
- R6: Writing status with bit 5 at 1 puts the count at 0 and clears the flag. Bit 5 always reads back as 0.
- R7: A divider code p of 0 to 8 gives one counter step per 2^p source ticks. Codes 9 to 15 act as code 8. The first step after a start lands on source tick 2^p.
- R8: `irq` is high exactly while the flag is set and status bit 6 is 1.
- R9: The flag clears only on a status write with bit 7 at 0 that follows a status read (`busRd` at address 0) made while the flag was set. A status write without that read leaves the flag set.
- R10: Source code 0 counts every bus clock, 1 counts cycles with `fixedTick` high, 2 counts falling edges of `extPin` and 3 counts rising edges of `extPin`. The pin passes through a two-stage synchronizer first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| fixedTick | input | 1 | Fixed-rate clock enable, one bus cycle wide |
| extPin | input | 1 | Asynchronous external tick pin |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (arms the flag clear) |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data |
| irq | output | 1 | Overflow interrupt request |

## Verification
The properties assume single-cycle bus strobes sampled at the clock edge. They also assume `fixedTick` is a clean one-cycle enable. The bench keeps to this by changing every input on the falling clock edge and lowering each strobe after one rising edge. It holds `extPin` steady for four bus cycles per level, so the synchronizer and edge detector see each transition exactly once. The interrupt property ignores cycles with a status write, because such a write may change the enable bit in that same edge. The bench checks that case through the `irq` port instead.

// File: rtl/mtim_pkg.sv
package mtim_pkg;
  // Strobes passed from the control block to the counter datapath.
  typedef struct packed {
    logic tick;        // divided counting tick
    logic clearCount;  // restart or limit write
  } mtimStrobes_t;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_SETUP  = 2'd1;
  localparam logic [1:0] ADDR_COUNT  = 2'd2;
  localparam logic [1:0] ADDR_LIMIT  = 2'd3;

  localparam logic [1:0] SRC_BUS  = 2'd0;
  localparam logic [1:0] SRC_FIX  = 2'd1;
  localparam logic [1:0] SRC_FALL = 2'd2;
  localparam logic [1:0] SRC_RISE = 2'd3;
endpackage

// File: rtl/mtim_ctrl.sv
module mtim_ctrl
  import mtim_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fixedTick,
  input  logic             extPin,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [1:0]       busAddr,
  input  logic [7:0]       busWdata,
  input  logic [CNT_W-1:0] countVal,
  input  logic             wrapEvt,
  output logic [7:0]       busRdata,
  output logic             irq,
  output mtimStrobes_t     strobes,
  output logic [CNT_W-1:0] modVal,
  output logic             flagVal,
  output logic             irqEnVal,
  output logic             haltVal
);
  localparam int MAX_SHIFT = CNT_W;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   extPrev;
  logic [1:0]             srcSel;
  logic [PRE_W-1:0]       preCode;
  logic [CNT_W-1:0]       divQ;
  logic                   armQ;
  logic                   srcTick;
  logic [PRE_W-1:0]       shiftAmt;
  logic [CNT_W:0]         fullDiv;
  logic [CNT_W-1:0]       divMask;
  logic                   statusWr, setupWr, limitWr, restartReq;
  logic                   flagNext;
  logic                   extLevel;

  assign extLevel = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      extPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], extPin};
      extPrev <= extLevel;
    end
  end

  always_comb begin
    unique case (srcSel)
      SRC_BUS:  srcTick = 1'b1;
      SRC_FIX:  srcTick = fixedTick;
      SRC_FALL: srcTick = extPrev && !extLevel;
      default:  srcTick = !extPrev && extLevel;
    endcase
  end

  assign shiftAmt = (int'(preCode) > MAX_SHIFT) ? PRE_W'(MAX_SHIFT) : preCode;
  assign fullDiv  = (CNT_W+1)'(1) << shiftAmt;
  assign divMask  = CNT_W'(fullDiv - (CNT_W+1)'(1));

  assign statusWr   = busWr && (busAddr == ADDR_STATUS);
  assign setupWr    = busWr && (busAddr == ADDR_SETUP);
  assign limitWr    = busWr && (busAddr == ADDR_LIMIT);
  assign restartReq = statusWr && busWdata[5];

  assign strobes.clearCount = restartReq || limitWr;
  assign strobes.tick       = !haltVal && srcTick && ((divQ & divMask) == divMask);

  always_comb begin
    flagNext = flagVal;
    if (strobes.clearCount)                      flagNext = 1'b0;
    else if (wrapEvt)                            flagNext = 1'b1;
    else if (statusWr && armQ && !busWdata[7])   flagNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divQ     <= '0;
      flagVal  <= 1'b0;
      armQ     <= 1'b0;
      irqEnVal <= 1'b0;
      haltVal  <= 1'b1;
      srcSel   <= SRC_BUS;
      preCode  <= '0;
      modVal   <= '0;
    end else begin
      if (haltVal || strobes.clearCount) divQ <= '0;
      else if (srcTick)                  divQ <= divQ + 1'b1;
      flagVal <= flagNext;
      if (!flagNext)                                          armQ <= 1'b0;
      else if (busRd && busAddr == ADDR_STATUS && flagVal)    armQ <= 1'b1;
      if (statusWr) begin
        irqEnVal <= busWdata[6];
        haltVal  <= busWdata[4];
      end
      if (setupWr) begin
        srcSel  <= busWdata[5:4];
        preCode <= busWdata[PRE_W-1:0];
      end
      if (limitWr) modVal <= busWdata[CNT_W-1:0];
    end
  end

  always_comb begin
    unique case (busAddr)
      ADDR_STATUS: busRdata = {flagVal, irqEnVal, 1'b0, haltVal, 4'b0};
      ADDR_SETUP:  busRdata = {2'b0, srcSel, preCode};
      ADDR_COUNT:  busRdata = countVal;
      default:     busRdata = modVal;
    endcase
  end

  assign irq = flagVal && irqEnVal;
endmodule

// File: rtl/mtim_datapath.sv
module mtim_datapath
  import mtim_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  mtimStrobes_t     strobes,
  input  logic [CNT_W-1:0] modVal,
  output logic [CNT_W-1:0] countVal,
  output logic             wrapEvt
);
  logic [CNT_W-1:0] wrapAt;
  logic             atWrap;

  assign wrapAt  = (modVal == '0) ? '1 : modVal;
  assign atWrap  = (countVal == wrapAt);
  assign wrapEvt = strobes.tick && atWrap && !strobes.clearCount;

  always_ff @(posedge clk) begin
    if (!rstN)                   countVal <= '0;
    else if (strobes.clearCount) countVal <= '0;
    else if (strobes.tick)       countVal <= atWrap ? '0 : countVal + 1'b1;
  end
endmodule

// File: rtl/mod_overflow_timer.sv
module mod_overflow_timer
  import mtim_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fixedTick,
  input  logic       extPin,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [1:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       irq
);
  mtimStrobes_t     strobes;
  logic [CNT_W-1:0] countVal;
  logic [CNT_W-1:0] modVal;
  logic             wrapEvt, flagVal, irqEnVal, haltVal;

  mtim_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .fixedTick(fixedTick), .extPin(extPin),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWdata(busWdata),
    .countVal(countVal), .wrapEvt(wrapEvt), .busRdata(busRdata), .irq(irq),
    .strobes(strobes), .modVal(modVal), .flagVal(flagVal),
    .irqEnVal(irqEnVal), .haltVal(haltVal)
  );

  mtim_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .modVal(modVal),
    .countVal(countVal), .wrapEvt(wrapEvt)
  );
endmodule

// File: rtl/mtim_checker.sv
module mtim_checker
  import mtim_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             busWr,
  input logic [1:0]       busAddr,
  input mtimStrobes_t     strobes,
  input logic [CNT_W-1:0] countVal,
  input logic             wrapEvt,
  input logic             flagVal,
  input logic             irqEnVal,
  input logic             haltVal,
  input logic             irq
);
  // R1: without a tick or a clear the count holds
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.tick && !strobes.clearCount) |=> $stable(countVal));

  // R2 / R3: a wrap lands on zero with the flag set
  p_wrap_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvt |=> (countVal == '0) && flagVal);

  // R4 / R6: restart or limit write zeroes count and flag
  p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearCount |=> (countVal == '0) && !flagVal);

  // R5: halted counter holds unless cleared
  p_halt_r5: assert property (@(posedge clk) disable iff (!rstN)
    (haltVal && !strobes.clearCount) |=> $stable(countVal));

  // R8: a wrap with the enable set raises the request
  p_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrapEvt && irqEnVal && !(busWr && busAddr == ADDR_STATUS)) |=> irq);
endmodule

bind mod_overflow_timer mtim_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
  .strobes(strobes), .countVal(countVal), .wrapEvt(wrapEvt),
  .flagVal(flagVal), .irqEnVal(irqEnVal), .haltVal(haltVal), .irq(irq)
);

// File: tb/mod_overflow_timer_test.sv
module mod_overflow_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int NVEC       = 8;

  // {divider code, limit, cycles, expected count, expected flag}
  typedef struct packed {
    logic [3:0]  pre;
    logic [7:0]  lim;
    logic [15:0] cyc;
    logic [7:0]  expCount;
    logic        expFlag;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'd0,  8'd10, 16'd7,   8'd7,  1'b0},   // R1 plain count
    '{4'd0,  8'd5,  16'd6,   8'd0,  1'b1},   // R2 wrap at limit
    '{4'd2,  8'd0,  16'd40,  8'd10, 1'b0},   // R7 divide by 4
    '{4'd1,  8'd3,  16'd9,   8'd0,  1'b1},   // R7 divide by 2 with wrap
    '{4'd12, 8'd0,  16'd600, 8'd2,  1'b0},   // R7 undefined code acts as 256
    '{4'd8,  8'd0,  16'd512, 8'd2,  1'b0},   // R7 divide by 256
    '{4'd0,  8'd0,  16'd300, 8'd44, 1'b1},   // R3 free run wrap at 255
    '{4'd3,  8'd2,  16'd20,  8'd2,  1'b0}    // R7 divide by 8
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fixedTick = 1'b0;
  logic       extPin = 1'b0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  mod_overflow_timer uut (
    .clk(clk), .rstN(rstN), .fixedTick(fixedTick), .extPin(extPin),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1 busWr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic rdStatus();
    @(negedge clk);
    busRd = 1'b1; busAddr = 2'd0;
    @(posedge clk);
    #1 busRd = 1'b0;
  endtask

  task automatic startRun(input logic [1:0] src, input logic [3:0] pre,
                          input logic [7:0] lim, input logic ie);
    wrReg(2'd0, 8'h10);
    wrReg(2'd1, {2'b00, src, pre});
    wrReg(2'd3, lim);
    wrReg(2'd0, {1'b0, ie, 6'b0});
  endtask

  initial begin
    logic [7:0] d, c1;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);

    // R5 reset state
    peek(2'd0, d); check("R5 reset status", d, 8'h10);
    peek(2'd1, d); check("R5 reset setup", d, 8'h00);
    peek(2'd2, d); check("R5 reset count", d, 8'h00);
    peek(2'd3, d); check("R5 reset limit", d, 8'h00);
    check("R8 reset irq", {7'b0, irq}, 8'h00);

    // R1 count register is read-only
    wrReg(2'd2, 8'h55);
    peek(2'd2, d); check("R1 count write ignored", d, 8'h00);

    // vector table on the bus-clock source
    for (int v = 0; v < NVEC; v++) begin
      startRun(2'd0, VECS[v].pre, VECS[v].lim, 1'b1);
      repeat (int'(VECS[v].cyc)) @(posedge clk);
      peek(2'd2, d); check($sformatf("R1/R2/R3/R7 vec%0d count", v), d, VECS[v].expCount);
      peek(2'd0, d); check($sformatf("R2 vec%0d flag", v), {7'b0, d[7]}, {7'b0, VECS[v].expFlag});
      check($sformatf("R8 vec%0d irq", v), {7'b0, irq}, {7'b0, VECS[v].expFlag});
    end

    // R5 halt holds the count
    startRun(2'd0, 4'd0, 8'd0, 1'b1);
    repeat (5) @(posedge clk);
    wrReg(2'd0, 8'h50);
    peek(2'd2, c1);
    check("R5 count moved before halt", {7'b0, c1 != 8'd0}, 8'h01);
    repeat (10) @(posedge clk);
    peek(2'd2, d); check("R5 halted count", d, c1);

    // R6 restart bit
    startRun(2'd0, 4'd0, 8'd5, 1'b1);
    repeat (8) @(posedge clk);
    peek(2'd0, d); check("R6 precondition flag", d, 8'hC0);
    wrReg(2'd0, 8'h70);
    peek(2'd2, d); check("R6 restart count", d, 8'h00);
    peek(2'd0, d); check("R6 restart status reads bit5 as 0", d, 8'h50);

    // R4 limit write
    startRun(2'd0, 4'd0, 8'd5, 1'b1);
    repeat (8) @(posedge clk);
    wrReg(2'd3, 8'd5);
    peek(2'd2, d); check("R4 limit write count", d, 8'h00);
    peek(2'd0, d); check("R4 limit write flag", {7'b0, d[7]}, 8'h00);

    // R9 flag clear sequence
    startRun(2'd0, 4'd0, 8'd2, 1'b1);
    repeat (4) @(posedge clk);
    wrReg(2'd0, 8'h50);
    peek(2'd0, d); check("R9 write without read keeps flag", d, 8'hD0);
    check("R8 irq with flag and enable", {7'b0, irq}, 8'h01);
    rdStatus();
    wrReg(2'd0, 8'h50);
    peek(2'd0, d); check("R9 read then write clears flag", d, 8'h50);
    check("R8 irq after clear", {7'b0, irq}, 8'h00);

    // R8 enable off
    startRun(2'd0, 4'd0, 8'd2, 1'b0);
    repeat (4) @(posedge clk);
    peek(2'd0, d); check("R8 flag set enable off", d, 8'h80);
    check("R8 irq masked", {7'b0, irq}, 8'h00);

    // R10 fixed tick source
    startRun(2'd1, 4'd0, 8'd0, 1'b0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk) fixedTick = 1'b1;
      @(negedge clk) fixedTick = 1'b0;
      repeat (2) @(negedge clk);
    end
    peek(2'd2, d); check("R10 fixed tick count", d, 8'd5);

    // R7 with fixed tick, divide by 2
    startRun(2'd1, 4'd1, 8'd0, 1'b0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk) fixedTick = 1'b1;
      @(negedge clk) fixedTick = 1'b0;
      @(negedge clk);
    end
    peek(2'd2, d); check("R7 fixed tick divide by 2", d, 8'd3);

    // R10 rising edges of the pin
    startRun(2'd3, 4'd0, 8'd0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) extPin = 1'b1;
      repeat (4) @(negedge clk);
      extPin = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    peek(2'd2, d); check("R10 rising edge count", d, 8'd3);

    // R10 falling edges of the pin
    startRun(2'd2, 4'd0, 8'd0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) extPin = 1'b1;
      repeat (4) @(negedge clk);
      extPin = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    peek(2'd2, d); check("R10 falling edge count", d, 8'd3);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule